// File: doc/BRIEF.md
# Interrupt Source Coalescing Tracker

This block holds the interrupt state for a small bank of sources. For each source it keeps the following:
- a destination server and a priority;
- a priority saved across masking;
- an edge or level mode flag;
- a two-bit coalescing state, with a presented bit P in bit 0 and a queued bit Q in bit 1;
- a masked-pending flag and a resend flag.

It takes four kinds of input. Trigger events carry a line level. End-of-interrupt notices shift the coalescing state. Configuration writes set, mask or unmask the priority. The presentation controller returns rejected sources, and a resend request re-issues every rejected source.

Any source that needs presenting raises an internal request. A fixed arbiter takes one request per clock, lowest index first. A granted source whose priority is not masked appears on a registered presentation output that carries the source number, server and priority. A granted source that is masked does not appear. Instead it sets its masked-pending flag, so the event is kept until the priority is unmasked.

Top module: `pq_source_bank`

## Requirements
- R1: After reset no presentation is output, and every source has priority 0xFF (masked) and saved priority 0xFF. Its coalescing state and flags are zero.
- R2: A trigger with level 1 on an edge source sets the state to {old P, 1}, with P in bit 0 and Q in bit 1. The source asks for presentation only if the new state is P=1, Q=0.
- R3: A trigger with level 0 on an edge source leaves its state unchanged.
- R4: On a level source, a trigger with level 1 while P is set changes nothing. A trigger with level 1 while P is clear sets the state to P only and asks for presentation. A trigger with level 0 clears both bits.
- R5: An end-of-interrupt shifts the state right by one, so Q moves into P and Q becomes 0. If P is then set, the source asks for presentation again.
- R6: A granted source whose priority is 0xFF sets masked-pending and drives no presentation.
- R7: A configuration write that leaves the priority other than 0xFF re-presents the source and clears masked-pending and resend, provided masked-pending or resend was set. This includes the case where the source is granted while masked in the same cycle.
- R8: cfg_op 0 sets server, priority, saved priority and mode (cfg_level 1 = level). cfg_op 1 masks: the priority becomes 0xFF and the current priority is saved, unless the source is already masked. cfg_op 2 restores the saved priority. cfg_op 3 changes nothing.
- R9: A reject sets the source's resend flag. A resend request makes every source with the resend flag set ask for presentation and clears those flags. A reject in the same cycle wins for its source.
- R10: At most one source is granted per cycle, the lowest-indexed requester first. A request registered at clock edge k is granted in the cycle after edge k. When the priority is unmasked, it appears on the pres_* outputs after edge k+1, carrying the source's current server and priority.
- R11: A trigger and an end-of-interrupt on the same source in one cycle apply in that order. In that case the source asks for presentation only if P is set in the final state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Trigger event strobe |
| trig_src | input | SRC_W | Triggered source index |
| trig_level | input | 1 | Line level of the trigger |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_src | input | SRC_W | Source being ended |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 set, 1 mask, 2 unmask, 3 no-op |
| cfg_src | input | SRC_W | Source being configured |
| cfg_server | input | SRV_W | Server for set |
| cfg_prio | input | 8 | Priority for set (0xFF = masked) |
| cfg_level | input | 1 | Mode for set, 1 = level |
| rej_valid | input | 1 | Reject return strobe |
| rej_src | input | SRC_W | Rejected source |
| resend_req | input | 1 | Re-present all rejected sources |
| pres_valid | output | 1 | Presentation request valid |
| pres_src | output | SRC_W | Presented source index |
| pres_server | output | SRV_W | Destination server |
| pres_prio | output | 8 | Presented priority |

## Verification
The functions most likely to collide are a trigger and an end-of-interrupt on one source in the same cycle. The bench provokes this directly, once from an idle state and once from a presented state. It judges the result by whether a presentation follows one cycle later. A second collision is an unmask write landing in the cycle where the same masked source is granted. Long random runs over all sixteen sources with frequent same-index hits produce such overlaps, and a per-cycle reference model built from the requirements compares every presentation output, including the lowest-index-first ordering after a resend burst.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int          PRIO_W      = 8;
  localparam logic [7:0]  PRIO_MASKED = 8'hFF;

  typedef enum logic [1:0] {
    CFG_SET    = 2'd0,
    CFG_MASK   = 2'd1,
    CFG_UNMASK = 2'd2,
    CFG_NOP    = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/pq_src_cell.sv
module pq_src_cell
  import pq_pkg::*;
#(
  parameter int SRV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_hit,
  input  logic              trig_level,
  input  logic              eoi_hit,
  input  logic              cfg_hit,
  input  logic [1:0]        cfg_op,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_level,
  input  logic              rej_hit,
  input  logic              resend_req,
  input  logic              grant,
  output logic              want_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [SRV_W-1:0]  server_o,
  output logic [1:0]        pq_o,
  output logic              mpend_o,
  output logic              resend_o
);
  logic [1:0]        pq_q, pq_trig, pq_next;
  logic [PRIO_W-1:0] prio_q, prio_next, saved_q, saved_next;
  logic [SRV_W-1:0]  server_q, server_next;
  logic              level_q, level_next;
  logic              mpend_q, mpend_next, resend_q, resend_next;
  logic              want_q, want_next;
  logic              trig_pres, new_pres, cfg_act, grant_masked, repres;
  cfg_op_e           op;

  assign op = cfg_op_e'(cfg_op);

  // coalescing state: trigger first, then end-of-interrupt
  always_comb begin
    pq_trig   = pq_q;
    trig_pres = 1'b0;
    if (trig_hit) begin
      if (level_q) begin
        if (!trig_level) begin
          pq_trig = 2'b00;
        end else if (!pq_q[0]) begin
          pq_trig   = 2'b01;
          trig_pres = 1'b1;
        end
      end else if (trig_level) begin
        pq_trig   = {pq_q[0], 1'b1};
        trig_pres = (pq_trig == 2'b01);
      end
    end
    pq_next  = pq_trig;
    new_pres = trig_pres;
    if (eoi_hit) begin
      pq_next  = {1'b0, pq_trig[1]};
      new_pres = pq_trig[1];
    end
  end

  // configuration
  always_comb begin
    prio_next   = prio_q;
    saved_next  = saved_q;
    server_next = server_q;
    level_next  = level_q;
    if (cfg_hit) begin
      case (op)
        CFG_SET: begin
          server_next = cfg_server;
          prio_next   = cfg_prio;
          saved_next  = cfg_prio;
          level_next  = cfg_level;
        end
        CFG_MASK: begin
          if (prio_q != PRIO_MASKED) saved_next = prio_q;
          prio_next = PRIO_MASKED;
        end
        CFG_UNMASK: prio_next = saved_q;
        default: ;
      endcase
    end
  end

  // flags and presentation request
  always_comb begin
    cfg_act      = cfg_hit && (op != CFG_NOP);
    grant_masked = grant && (prio_q == PRIO_MASKED);
    repres       = cfg_act && (prio_next != PRIO_MASKED) &&
                   (mpend_q || resend_q || grant_masked);
    mpend_next   = repres ? 1'b0 : (mpend_q || grant_masked);
    if (rej_hit)                  resend_next = 1'b1;
    else if (repres || resend_req) resend_next = 1'b0;
    else                          resend_next = resend_q;
    want_next = (want_q && !grant) || new_pres || repres ||
                (resend_req && resend_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pq_q     <= 2'b00;
      prio_q   <= PRIO_MASKED;
      saved_q  <= PRIO_MASKED;
      server_q <= '0;
      level_q  <= 1'b0;
      mpend_q  <= 1'b0;
      resend_q <= 1'b0;
      want_q   <= 1'b0;
    end else begin
      pq_q     <= pq_next;
      prio_q   <= prio_next;
      saved_q  <= saved_next;
      server_q <= server_next;
      level_q  <= level_next;
      mpend_q  <= mpend_next;
      resend_q <= resend_next;
      want_q   <= want_next;
    end
  end

  assign want_o   = want_q;
  assign prio_o   = prio_q;
  assign server_o = server_q;
  assign pq_o     = pq_q;
  assign mpend_o  = mpend_q;
  assign resend_o = resend_q;
endmodule

// File: rtl/pq_low_arb.sv
module pq_low_arb #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  assign grant = req & (~req + N'(1));
  assign any   = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pq_present_reg.sv
module pq_present_reg
  import pq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int SRV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_any,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [SRV_W-1:0]  sel_server,
  input  logic [PRIO_W-1:0] sel_prio,
  output logic              pres_valid,
  output logic [IDX_W-1:0]  pres_src,
  output logic [SRV_W-1:0]  pres_server,
  output logic [PRIO_W-1:0] pres_prio
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pres_valid  <= 1'b0;
      pres_src    <= '0;
      pres_server <= '0;
      pres_prio   <= PRIO_MASKED;
    end else begin
      pres_valid  <= sel_any && (sel_prio != PRIO_MASKED);
      pres_src    <= sel_idx;
      pres_server <= sel_server;
      pres_prio   <= sel_prio;
    end
  end
endmodule

// File: rtl/pq_source_bank.sv
module pq_source_bank
  import pq_pkg::*;
#(
  parameter int N     = 16,
  parameter int SRV_W = 4,
  parameter int SRC_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_valid,
  input  logic [SRC_W-1:0]  trig_src,
  input  logic              trig_level,
  input  logic              eoi_valid,
  input  logic [SRC_W-1:0]  eoi_src,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_op,
  input  logic [SRC_W-1:0]  cfg_src,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [7:0]        cfg_prio,
  input  logic              cfg_level,
  input  logic              rej_valid,
  input  logic [SRC_W-1:0]  rej_src,
  input  logic              resend_req,
  output logic              pres_valid,
  output logic [SRC_W-1:0]  pres_src,
  output logic [SRV_W-1:0]  pres_server,
  output logic [7:0]        pres_prio
);
  logic [N-1:0]        want_vec, grant_vec, resend_vec, mpend_vec;
  logic [2*N-1:0]      pq_flat;
  logic [PRIO_W-1:0]   prio_arr   [N];
  logic [SRV_W-1:0]    server_arr [N];
  logic                sel_any;
  logic [SRC_W-1:0]    sel_idx;

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam logic [SRC_W-1:0] MY_IDX = SRC_W'(i);
    pq_src_cell #(.SRV_W(SRV_W)) u_cell (
      .clk        (clk),
      .rst        (rst),
      .trig_hit   (trig_valid && (trig_src == MY_IDX)),
      .trig_level (trig_level),
      .eoi_hit    (eoi_valid && (eoi_src == MY_IDX)),
      .cfg_hit    (cfg_valid && (cfg_src == MY_IDX)),
      .cfg_op     (cfg_op),
      .cfg_server (cfg_server),
      .cfg_prio   (cfg_prio),
      .cfg_level  (cfg_level),
      .rej_hit    (rej_valid && (rej_src == MY_IDX)),
      .resend_req (resend_req),
      .grant      (grant_vec[i]),
      .want_o     (want_vec[i]),
      .prio_o     (prio_arr[i]),
      .server_o   (server_arr[i]),
      .pq_o       (pq_flat[2*i +: 2]),
      .mpend_o    (mpend_vec[i]),
      .resend_o   (resend_vec[i])
    );
  end

  pq_low_arb #(.N(N), .IDX_W(SRC_W)) u_arb (
    .req   (want_vec),
    .grant (grant_vec),
    .any   (sel_any),
    .idx   (sel_idx)
  );

  pq_present_reg #(.IDX_W(SRC_W), .SRV_W(SRV_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .sel_any     (sel_any),
    .sel_idx     (sel_idx),
    .sel_server  (server_arr[sel_idx]),
    .sel_prio    (prio_arr[sel_idx]),
    .pres_valid  (pres_valid),
    .pres_src    (pres_src),
    .pres_server (pres_server),
    .pres_prio   (pres_prio)
  );
endmodule

// File: rtl/pq_source_bank_chk.sv
module pq_source_bank_chk #(
  parameter int N     = 16,
  parameter int SRC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pres_valid,
  input logic [SRC_W-1:0] pres_src,
  input logic [7:0]       pres_prio,
  input logic [N-1:0]     want_vec,
  input logic [N-1:0]     resend_vec,
  input logic [N-1:0]     mpend_vec,
  input logic             rej_valid,
  input logic             resend_req,
  input logic             eoi_valid,
  input logic [SRC_W-1:0] eoi_src,
  input logic [2*N-1:0]   pq_flat
);
  logic [N-1:0] below_mask, own_bit;
  assign own_bit    = N'(1) << pres_src;
  assign below_mask = own_bit - N'(1);

  // R6
  masked_never_out_chk: assert property (@(posedge clk) disable iff (rst)
    pres_valid |-> (pres_prio != 8'hFF));

  // R10
  lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
    pres_valid |-> ((($past(want_vec) & below_mask) == '0) &&
                    (($past(want_vec) & own_bit) != '0)));

  // R10
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (rst)
    pres_valid |-> $past(|want_vec));

  // R9
  resend_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (resend_req && !rej_valid) |=> (resend_vec == '0));

  // R6
  mpend_only_masked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(|mpend_vec) |-> !pres_valid || (pres_prio != 8'hFF));

  for (genvar i = 0; i < N; i++) begin : g_eoi
    // R5
    eoi_drops_q_chk: assert property (@(posedge clk) disable iff (rst)
      (eoi_valid && (eoi_src == SRC_W'(i))) |=> !pq_flat[2*i+1]);
  end
endmodule

bind pq_source_bank pq_source_bank_chk #(.N(N), .SRC_W(SRC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pres_valid (pres_valid),
  .pres_src   (pres_src),
  .pres_prio  (pres_prio),
  .want_vec   (want_vec),
  .resend_vec (resend_vec),
  .mpend_vec  (mpend_vec),
  .rej_valid  (rej_valid),
  .resend_req (resend_req),
  .eoi_valid  (eoi_valid),
  .eoi_src    (eoi_src),
  .pq_flat    (pq_flat)
);

// File: tb/pq_source_bank_tb.sv
module pq_source_bank_tb;
  localparam int N = 16, SRV_W = 4, SRC_W = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic trig_valid = 0, trig_level = 0, eoi_valid = 0, cfg_valid = 0, cfg_level = 0;
  logic rej_valid = 0, resend_req = 0;
  logic [SRC_W-1:0] trig_src = 0, eoi_src = 0, cfg_src = 0, rej_src = 0;
  logic [1:0] cfg_op = 0;
  logic [SRV_W-1:0] cfg_server = 0;
  logic [7:0] cfg_prio = 0;
  logic pres_valid;
  logic [SRC_W-1:0] pres_src;
  logic [SRV_W-1:0] pres_server;
  logic [7:0] pres_prio;

  always #2 clk = ~clk;

  pq_source_bank #(.N(N), .SRV_W(SRV_W)) u_dut (.*);

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  int m_pq[N], m_pr[N], m_sv[N], m_srv[N];
  bit m_lv[N], m_mp[N], m_rs[N], m_w[N];
  bit e_pv = 0;
  int e_src = 0, e_srv = 0, e_pr = 0;

  task automatic chk(bit ok, string tag, string act, string exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic model_tick(bit tv, int ts, bit tl, bit ev, int es, bit cv, int cop,
                            int cs, int csrv, int cpr, bit clv, bit rv, int rs, bit rq);
    int g = -1;
    for (int i = N - 1; i >= 0; i--) if (m_w[i]) g = i;
    e_pv = (g >= 0) && (m_pr[g] != 255);
    if (g >= 0) begin e_src = g; e_srv = m_srv[g]; e_pr = m_pr[g]; end
    for (int i = 0; i < N; i++) begin
      int pqt = m_pq[i], np, nsv = m_sv[i], nsrv = m_srv[i];
      bit tp = 0, pres, nlv = m_lv[i], gm, rep, act;
      if (tv && ts == i) begin
        if (m_lv[i]) begin
          if (!tl) pqt = 0;
          else if ((m_pq[i] & 1) == 0) begin pqt = 1; tp = 1; end
        end else if (tl) begin
          pqt = ((m_pq[i] << 1) & 3) | 1;
          tp = (pqt == 1);
        end
      end
      pres = tp;
      if (ev && es == i) begin pqt = pqt >> 1; pres = pqt & 1; end
      np = m_pr[i];
      act = cv && cs == i && cop != 3;
      if (cv && cs == i) begin
        if (cop == 0) begin nsrv = csrv; np = cpr; nsv = cpr; nlv = clv; end
        else if (cop == 1) begin if (m_pr[i] != 255) nsv = m_pr[i]; np = 255; end
        else if (cop == 2) np = m_sv[i];
      end
      gm = (g == i) && (m_pr[i] == 255);
      rep = act && np != 255 && (m_mp[i] || m_rs[i] || gm);
      m_w[i] = (m_w[i] && g != i) || pres || rep || (rq && m_rs[i]);
      m_mp[i] = rep ? 0 : (m_mp[i] || gm);
      m_rs[i] = (rv && rs == i) ? 1 : ((rep || rq) ? 0 : m_rs[i]);
      m_pq[i] = pqt; m_pr[i] = np; m_sv[i] = nsv; m_srv[i] = nsrv; m_lv[i] = nlv;
    end
  endtask

  task automatic step(bit tv, int ts, bit tl, bit ev, int es, bit cv, int cop, int cs,
                      int csrv, int cpr, bit clv, bit rv, int rs, bit rq);
    trig_valid = tv; trig_src = SRC_W'(ts); trig_level = tl;
    eoi_valid = ev; eoi_src = SRC_W'(es);
    cfg_valid = cv; cfg_op = 2'(cop); cfg_src = SRC_W'(cs);
    cfg_server = SRV_W'(csrv); cfg_prio = 8'(cpr); cfg_level = clv;
    rej_valid = rv; rej_src = SRC_W'(rs); resend_req = rq;
    @(posedge clk);
    model_tick(tv, ts, tl, ev, es, cv, cop, cs, csrv, cpr, clv, rv, rs, rq);
    @(negedge clk);
    chk((pres_valid == e_pv) &&
        (!e_pv || (pres_src == SRC_W'(e_src) && pres_server == SRV_W'(e_srv) &&
                   pres_prio == 8'(e_pr))),
        "R10 model",
        $sformatf("v%0d s%0d srv%0d p%0d", pres_valid, pres_src, pres_server, pres_prio),
        $sformatf("v%0d s%0d srv%0d p%0d", e_pv, e_src, e_srv, e_pr));
    trig_valid = 0; eoi_valid = 0; cfg_valid = 0; rej_valid = 0; resend_req = 0;
  endtask

  task automatic idle();                 step(0,0,0,0,0,0,0,0,0,0,0,0,0,0); endtask
  task automatic trig(int s, bit l);     step(1,s,l,0,0,0,0,0,0,0,0,0,0,0); endtask
  task automatic eoi(int s);             step(0,0,0,1,s,0,0,0,0,0,0,0,0,0); endtask
  task automatic trig_eoi(int s);        step(1,s,1,1,s,0,0,0,0,0,0,0,0,0); endtask
  task automatic cfg(int op, int s, int srv, int pr, bit lv);
    step(0,0,0,0,0,1,op,s,srv,pr,lv,0,0,0);
  endtask
  task automatic rej(int s);             step(0,0,0,0,0,0,0,0,0,0,0,1,s,0); endtask
  task automatic resend();               step(0,0,0,0,0,0,0,0,0,0,0,0,0,1); endtask

  task automatic expect_out(bit v, int s, int srv, int pr, string tag);
    chk((pres_valid == v) && (!v || (pres_src == SRC_W'(s) &&
        pres_server == SRV_W'(srv) && pres_prio == 8'(pr))), tag,
        $sformatf("v%0d s%0d srv%0d p%0d", pres_valid, pres_src, pres_server, pres_prio),
        $sformatf("v%0d s%0d srv%0d p%0d", v, s, srv, pr));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_pq[i] = 0; m_pr[i] = 255; m_sv[i] = 255; m_srv[i] = 0;
      m_lv[i] = 0; m_mp[i] = 0; m_rs[i] = 0; m_w[i] = 0;
    end
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    expect_out(0, 0, 0, 0, "R1 reset output");
    // R1: reset priority masked, trigger is held back
    trig(3, 1); idle(); expect_out(0, 0, 0, 0, "R1 masked after reset");
    // R7: unmasking write re-presents masked-pending source
    cfg(0, 3, 5, 4, 0); idle(); expect_out(1, 3, 5, 4, "R7 re-present");
    // R2: second trigger only queues
    trig(3, 1); idle(); expect_out(0, 0, 0, 0, "R2 queued no present");
    // R5: EOI moves Q into P
    eoi(3); idle(); expect_out(1, 3, 5, 4, "R5 eoi re-present");
    eoi(3); idle(); expect_out(0, 0, 0, 0, "R5 eoi empty");
    // R3: level 0 on edge source ignored
    trig(3, 0); idle(); expect_out(0, 0, 0, 0, "R3 ignored");
    trig(3, 1); idle(); expect_out(1, 3, 5, 4, "R3 state untouched");
    eoi(3); idle();
    // R4: level source
    cfg(0, 7, 2, 9, 1); idle();
    trig(7, 1); idle(); expect_out(1, 7, 2, 9, "R4 level assert");
    trig(7, 1); idle(); expect_out(0, 0, 0, 0, "R4 level held");
    trig(7, 0); idle(); expect_out(0, 0, 0, 0, "R4 level drop");
    trig(7, 1); idle(); expect_out(1, 7, 2, 9, "R4 level reassert");
    eoi(7); idle();
    // R8 / R6: mask saves, unmask restores
    cfg(1, 7, 0, 0, 0); trig(7, 1); idle(); expect_out(0, 0, 0, 0, "R6 masked grant");
    cfg(2, 7, 0, 0, 0); idle(); expect_out(1, 7, 2, 9, "R8 unmask restore");
    eoi(7); idle();
    cfg(1, 7, 0, 0, 0); cfg(1, 7, 0, 0, 0); cfg(2, 7, 0, 0, 0);
    trig(7, 1); idle(); expect_out(1, 7, 2, 9, "R8 double mask keeps saved");
    eoi(7); idle();
    // R9 / R10: rejects, resend burst, lowest first
    cfg(0, 1, 1, 2, 0); cfg(0, 12, 3, 6, 0);
    rej(12); rej(1); rej(3); resend();
    idle(); expect_out(1, 1, 1, 2, "R10 first lowest");
    idle(); expect_out(1, 3, 5, 4, "R10 second");
    idle(); expect_out(1, 12, 3, 6, "R10 third");
    idle(); expect_out(0, 0, 0, 0, "R9 burst done");
    resend(); idle(); expect_out(0, 0, 0, 0, "R9 flags cleared");
    // R11: trigger and EOI together
    trig_eoi(1); idle(); expect_out(0, 0, 0, 0, "R11 from idle");
    trig(1, 1); idle(); expect_out(1, 1, 1, 2, "R11 setup");
    trig_eoi(1); idle(); expect_out(1, 1, 1, 2, "R11 from presented");
    // random phase, compared against the model every cycle
    for (int c = 0; c < 3000; c++) begin
      int r = $urandom % 4;
      step(($urandom % 10) < 3, $urandom % N, ($urandom % 4) != 0,
           ($urandom % 10) < 2, $urandom % N,
           ($urandom % 10) < 2, $urandom % 4, $urandom % N, $urandom % 16,
           (r == 0) ? 255 : ($urandom % 255), $urandom % 2,
           ($urandom % 10) < 1, $urandom % N, ($urandom % 20) == 0);
    end
    finish_run();
  end
endmodule